// File: doc/BRIEF.md
# Reshapeable Dual-Port Block Memory

This block is a 4608-bit storage array with two fully independent access ports, A and B. Each port has its own clock, active-low clock enable, write enable, output enable, address and data lines. A static shape input sets whether the array is seen as 512 words of 9 bits or as 256 words of 18 bits. The 9- and 18-bit widths leave room for one parity bit per byte, but this block does not generate or check parity.

A second static input selects dual-port use or single-port use. In single-port use only port A is live. A parameter picks either registered reads, where the output updates on the active clock edge, or combinational reads, where the output follows the address. A parameter for each port picks whether that port acts on the rising or the falling clock edge. When a port's output enable is low, its data output is forced to zero and its valid flag is cleared. This zero output takes the place of a high-impedance bus.

Top module: `cfg_dpram`

## Requirements
- R1: With `wide_mode`=0 the array is 512 words of 9 bits. All 9 address bits select the word, `din_x[8:0]` is written, and a read returns the word on `dout_x[8:0]` with `dout_x[17:9]`=0.
- R2: With `wide_mode`=1 the array is 256 words of 18 bits. Word w is made of narrow location 2w (bits 8:0) and narrow location 2w+1 (bits 17:9). Address bit 8 is ignored.
- R3: On a port's active edge, with `cen_x`=0 and `wen_x`=1, `din_x` is written to the addressed word.
- R4: In registered-read mode, on the active edge with `cen_x`=0 and `wen_x`=0, the read register takes the addressed word. It holds its value on every other edge, including write edges.
- R5: With `cen_x`=1 a port neither writes nor updates its read register.
- R6: With `oe_x`=0 the port outputs `dout_x`=0 and `vld_x`=0. With `oe_x`=1, `vld_x`=1 and `dout_x` shows the read data.
- R7: If both ports write the same narrow location on the same edge, port A's data is stored.
- R8: A registered read from one port on the same edge as the other port's write to that address returns the data held before the write.
- R9: With `dual_mode`=0, port B writes nothing, and `dout_b`=0 and `vld_b`=0 whatever B's inputs are.
- R10: With `ASYNC_READ`=1, `dout_x` shows the word at the current address with no clock edge, whatever the clock enable is.
- R11: `FALL_A`/`FALL_B`=1 makes that port act on the falling edge of its clock. The value 0 makes it act on the rising edge.
- R12: `rst_n`=0 clears both read registers to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of the read registers |
| wide_mode | input | 1 | 1 = 256x18 shape, 0 = 512x9 shape |
| dual_mode | input | 1 | 1 = both ports live, 0 = port A only |
| clk_a | input | 1 | Port A clock |
| cen_a | input | 1 | Port A clock enable, active low |
| wen_a | input | 1 | Port A write (1) or read (0) |
| oe_a | input | 1 | Port A output enable |
| addr_a | input | 9 | Port A address |
| din_a | input | 18 | Port A write data |
| dout_a | output | 18 | Port A read data, zero when disabled |
| vld_a | output | 1 | Port A output valid |
| clk_b | input | 1 | Port B clock |
| cen_b | input | 1 | Port B clock enable, active low |
| wen_b | input | 1 | Port B write (1) or read (0) |
| oe_b | input | 1 | Port B output enable |
| addr_b | input | 9 | Port B address |
| din_b | input | 18 | Port B write data |
| dout_b | output | 18 | Port B read data, zero when disabled |
| vld_b | output | 1 | Port B output valid |

## Verification
The array is first filled through port A with a distinct value in every narrow location. After that, reads in both shapes show whether the word mapping and the half-word order are right. Directed patterns cover:
- cross-port readback, which separates real sharing of the storage from two private copies;
- writes with the clock enable high and output-enable toggling, which tell gating apart from real data loss;
- same-address write collisions and read-during-write, which expose a wrong port priority or new-data-forwarding;
- single-port use, which shows whether port B leaks into the storage or the outputs.

A second instance with combinational reads and falling-edge ports is checked between edges. This separates a real edge choice and a true address-following read from a registered output. Long mixed random traffic on narrow address ranges then forces frequent collisions in both shapes.

// File: rtl/cfg_dpram.sv
`timescale 1ns/1ps
module cfg_dpram #(
  parameter int LOC_W      = 9,
  parameter int LOCS       = 512,
  parameter bit ASYNC_READ = 1'b0,
  parameter bit FALL_A     = 1'b0,
  parameter bit FALL_B     = 1'b0
) (
  input  logic                       rst_n,
  input  logic                       wide_mode,
  input  logic                       dual_mode,
  input  logic                       clk_a,
  input  logic                       cen_a,
  input  logic                       wen_a,
  input  logic                       oe_a,
  input  logic [$clog2(LOCS)-1:0]    addr_a,
  input  logic [2*LOC_W-1:0]         din_a,
  output logic [2*LOC_W-1:0]         dout_a,
  output logic                       vld_a,
  input  logic                       clk_b,
  input  logic                       cen_b,
  input  logic                       wen_b,
  input  logic                       oe_b,
  input  logic [$clog2(LOCS)-1:0]    addr_b,
  input  logic [2*LOC_W-1:0]         din_b,
  output logic [2*LOC_W-1:0]         dout_b,
  output logic                       vld_b
);
  localparam int AW = $clog2(LOCS);
  localparam int WW = 2 * LOC_W;

  // Two banks, each written by one port only; a location's value is the XOR of both.
  logic [LOC_W-1:0] mem_a [LOCS];
  logic [LOC_W-1:0] mem_b [LOCS];

  logic          ck_a, ck_b;
  logic [AW-1:0] lo_a, hi_a, lo_b, hi_b;
  logic          wr_a, rd_a, wr_b, rd_b, b_blocked;
  logic [WW-1:0] word_a, word_b, q_a, q_b;

  assign ck_a = clk_a ^ FALL_A;
  assign ck_b = clk_b ^ FALL_B;

  assign lo_a = wide_mode ? {addr_a[AW-2:0], 1'b0} : addr_a;
  assign hi_a = {addr_a[AW-2:0], 1'b1};
  assign lo_b = wide_mode ? {addr_b[AW-2:0], 1'b0} : addr_b;
  assign hi_b = {addr_b[AW-2:0], 1'b1};

  assign wr_a = ~cen_a & wen_a;
  assign rd_a = ~cen_a & ~wen_a;
  assign wr_b = dual_mode & ~cen_b & wen_b;
  assign rd_b = dual_mode & ~cen_b & ~wen_b;

  // Same shape on both ports: equal low locations means an overlapping word.
  assign b_blocked = wr_a & (lo_a == lo_b);

  assign word_a = wide_mode ? {mem_a[hi_a] ^ mem_b[hi_a], mem_a[lo_a] ^ mem_b[lo_a]}
                            : {{LOC_W{1'b0}}, mem_a[lo_a] ^ mem_b[lo_a]};
  assign word_b = wide_mode ? {mem_a[hi_b] ^ mem_b[hi_b], mem_a[lo_b] ^ mem_b[lo_b]}
                            : {{LOC_W{1'b0}}, mem_a[lo_b] ^ mem_b[lo_b]};

  always_ff @(posedge ck_a) begin
    if (wr_a) begin
      mem_a[lo_a] <= din_a[LOC_W-1:0] ^ mem_b[lo_a];
      if (wide_mode) mem_a[hi_a] <= din_a[WW-1:LOC_W] ^ mem_b[hi_a];
    end
  end

  always_ff @(posedge ck_b) begin
    if (wr_b && !b_blocked) begin
      mem_b[lo_b] <= din_b[LOC_W-1:0] ^ mem_a[lo_b];
      if (wide_mode) mem_b[hi_b] <= din_b[WW-1:LOC_W] ^ mem_a[hi_b];
    end
  end

  always_ff @(posedge ck_a or negedge rst_n) begin
    if (!rst_n)    q_a <= '0;
    else if (rd_a) q_a <= word_a;
  end

  always_ff @(posedge ck_b or negedge rst_n) begin
    if (!rst_n)    q_b <= '0;
    else if (rd_b) q_b <= word_b;
  end

  assign dout_a = oe_a ? (ASYNC_READ ? word_a : q_a) : '0;
  assign vld_a  = oe_a;
  assign dout_b = (dual_mode & oe_b) ? (ASYNC_READ ? word_b : q_b) : '0;
  assign vld_b  = dual_mode & oe_b;

  assert_write_lands_R3: assert property (@(posedge ck_a) disable iff (!rst_n)
    wr_a |=> ((mem_a[$past(lo_a)] ^ mem_b[$past(lo_a)]) == $past(din_a[LOC_W-1:0])));

  assert_a_wins_R7: assert property (@(posedge ck_b) disable iff (!rst_n)
    (wr_a && wr_b && lo_a == lo_b) |=>
      ((mem_a[$past(lo_b)] ^ mem_b[$past(lo_b)]) == $past(din_a[LOC_W-1:0])));

  assert_ce_hold_R5: assert property (@(posedge ck_a) disable iff (!rst_n)
    cen_a |=> $stable(q_a));

  assert_single_b_ignored_R9: assert property (@(posedge ck_b) disable iff (!rst_n)
    !dual_mode |=> (mem_b[$past(lo_b)] == $past(mem_b[lo_b])));

  assert_oe_gate_R6: assert property (@(posedge ck_a) disable iff (!rst_n)
    $fell(oe_a) |-> (dout_a == '0 && !vld_a));
endmodule

// File: tb/tb_cfg_dpram.sv
`timescale 1ns/1ps
module tb_cfg_dpram;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wide_mode, dual_mode;
  logic cen_a, wen_a, oe_a, cen_b, wen_b, oe_b;
  logic [8:0]  addr_a, addr_b;
  logic [17:0] din_a, din_b;
  logic [17:0] dout_a, dout_b, as_dout_a, as_dout_b;
  logic vld_a, vld_b, as_vld_a, as_vld_b;

  cfg_dpram dut (
    .rst_n(rst_n), .wide_mode(wide_mode), .dual_mode(dual_mode),
    .clk_a(clk), .cen_a(cen_a), .wen_a(wen_a), .oe_a(oe_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(dout_a), .vld_a(vld_a),
    .clk_b(clk), .cen_b(cen_b), .wen_b(wen_b), .oe_b(oe_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(dout_b), .vld_b(vld_b));

  cfg_dpram #(.ASYNC_READ(1'b1), .FALL_A(1'b1), .FALL_B(1'b1)) dut_async (
    .rst_n(rst_n), .wide_mode(wide_mode), .dual_mode(dual_mode),
    .clk_a(clk), .cen_a(cen_a), .wen_a(wen_a), .oe_a(oe_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(as_dout_a), .vld_a(as_vld_a),
    .clk_b(clk), .cen_b(cen_b), .wen_b(wen_b), .oe_b(oe_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(as_dout_b), .vld_b(as_vld_b));

  logic [8:0]  ref_m [512];
  logic [17:0] qa_m, qb_m;
  int n_chk = 0, n_bad = 0;
  string cur_req = "R12";
  bit done = 0;

  function automatic logic [17:0] word_of(logic [8:0] a);
    if (wide_mode) return {ref_m[{a[7:0], 1'b1}], ref_m[{a[7:0], 1'b0}]};
    return {9'd0, ref_m[a]};
  endfunction

  task automatic put(logic [8:0] a, logic [17:0] d);
    if (wide_mode) begin
      ref_m[{a[7:0], 1'b0}] = d[8:0];
      ref_m[{a[7:0], 1'b1}] = d[17:9];
    end else ref_m[a] = d[8:0];
  endtask

  task automatic chk(string what, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    if (!cen_a && !wen_a) qa_m = word_of(addr_a);
    if (dual_mode && !cen_b && !wen_b) qb_m = word_of(addr_b);
    if (dual_mode && !cen_b && wen_b) put(addr_b, din_b);
    if (!cen_a && wen_a) put(addr_a, din_a);
    chk("dout_a", dout_a, oe_a ? qa_m : 18'd0);
    chk("vld_a", {17'd0, vld_a}, {17'd0, oe_a});
    chk("dout_b", dout_b, (dual_mode && oe_b) ? qb_m : 18'd0);
    chk("vld_b", {17'd0, vld_b}, {17'd0, dual_mode & oe_b});
    chk("async dout_a", as_dout_a, oe_a ? word_of(addr_a) : 18'd0);
    chk("async dout_b", as_dout_b, (dual_mode && oe_b) ? word_of(addr_b) : 18'd0);
  endtask

  task automatic pa(logic c, logic w, logic o, logic [8:0] a, logic [17:0] d);
    cen_a = c; wen_a = w; oe_a = o; addr_a = a; din_a = d;
  endtask
  task automatic pb(logic c, logic w, logic o, logic [8:0] a, logic [17:0] d);
    cen_b = c; wen_b = w; oe_b = o; addr_b = a; din_b = d;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) ref_m[i] = 9'd0;
    qa_m = '0; qb_m = '0;
    rst_n = 0; wide_mode = 0; dual_mode = 1;
    pa(1, 0, 1, 0, 0); pb(1, 0, 1, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R12";
    chk("reset dout_a", dout_a, 18'd0);
    chk("reset dout_b", dout_b, 18'd0);
    rst_n = 1;

    cur_req = "R3";
    pb(1, 0, 0, 0, 0);
    for (int i = 0; i < 512; i++) begin
      pa(0, 1, 0, 9'(i), 18'((i * 37 + 5) & 9'h1ff) | 18'h3fe00);
      cyc();
    end

    cur_req = "R1";
    for (int i = 0; i < 40; i++) begin
      pa(0, 0, 1, 9'(i * 13 + 3), 0);
      pb(0, 0, 1, 9'(511 - i * 7), 0);
      cyc();
    end

    cur_req = "R2"; wide_mode = 1;
    for (int i = 0; i < 20; i++) begin
      pa(0, 0, 1, 9'(i * 11), 0); pb(0, 0, 1, 9'(255 - i), 0); cyc();
    end
    pa(0, 1, 1, 9'h105, 18'h2a5c3); pb(1, 0, 1, 0, 0); cyc();
    pa(1, 0, 1, 0, 0); pb(0, 0, 1, 9'h005, 0); cyc();
    pb(1, 0, 1, 0, 0); cyc();
    wide_mode = 0; cur_req = "R2";
    pa(0, 0, 1, 9'h00a, 0); cyc();
    pa(0, 0, 1, 9'h00b, 0); cyc();
    pa(1, 0, 1, 0, 0); cyc();

    cur_req = "R4";
    pa(0, 0, 1, 9'd77, 0); cyc();
    pa(0, 1, 1, 9'd78, 18'h0ab); cyc();
    pa(1, 0, 1, 9'd78, 0); cyc();
    pa(0, 0, 1, 9'd78, 0); cyc();

    cur_req = "R5";
    pa(1, 1, 1, 9'd90, 18'h1ff); cyc();
    pa(1, 0, 1, 9'd91, 0); cyc();
    pa(0, 0, 1, 9'd90, 0); cyc();
    pa(1, 0, 1, 9'd90, 0); cyc();

    cur_req = "R6";
    for (int i = 0; i < 8; i++) begin
      pa(0, 0, i[0], 9'(200 + i), 0); pb(0, 0, i[1], 9'(300 + i), 0); cyc();
    end

    cur_req = "R7";
    pa(0, 1, 1, 9'd40, 18'h111); pb(0, 1, 1, 9'd40, 18'h0ee); cyc();
    pa(0, 0, 1, 9'd40, 0); pb(0, 1, 1, 9'd41, 18'h0cc); cyc();
    pa(0, 0, 1, 9'd41, 0); pb(1, 0, 1, 0, 0); cyc();
    wide_mode = 1;
    pa(0, 1, 1, 9'd20, 18'h12345); pb(0, 1, 1, 9'd20, 18'h0abcd); cyc();
    pa(1, 0, 1, 0, 0); pb(0, 0, 1, 9'd20, 0); cyc();
    pb(1, 0, 1, 0, 0); cyc();

    cur_req = "R8";
    pa(0, 0, 1, 9'd30, 0); pb(0, 1, 1, 9'd30, 18'h3c3c3); cyc();
    pa(0, 1, 1, 9'd31, 18'h15555); pb(0, 0, 1, 9'd31, 0); cyc();
    pa(0, 0, 1, 9'd30, 0); pb(0, 0, 1, 9'd31, 0); cyc();
    wide_mode = 0; pa(1, 0, 1, 0, 0); pb(1, 0, 1, 0, 0); cyc();

    cur_req = "R9"; dual_mode = 0;
    for (int i = 0; i < 6; i++) begin
      pa(0, 0, 1, 9'(60 + i), 0); pb(0, i[0], 1, 9'(60 + i), 18'h1a5); cyc();
    end
    dual_mode = 1;
    for (int i = 0; i < 6; i++) begin
      pa(0, 0, 1, 9'(60 + i), 0); pb(0, 0, 1, 9'(60 + i), 0); cyc();
    end

    cur_req = "R11";
    pb(1, 0, 0, 0, 0);
    pa(0, 1, 1, 9'd100, 18'h155);
    #1.5;
    chk("falling-edge write seen mid-cycle", as_dout_a, 18'h155);
    chk("rising-edge port unchanged mid-cycle", dout_a, qa_m);
    cyc();

    cur_req = "R10";
    pa(1, 0, 1, 9'd101, 0);
    #0.5;
    chk("async follows address", as_dout_a, {9'd0, ref_m[101]});
    cyc();

    cur_req = "R12";
    pa(0, 0, 1, 9'd5, 0); cyc();
    pa(1, 0, 1, 9'd5, 0);
    rst_n = 0; #0.5;
    chk("async clear dout_a", dout_a, 18'd0);
    qa_m = '0; qb_m = '0;
    rst_n = 1;
    cyc();

    cur_req = "R7/R8 random";
    for (int blk = 0; blk < 20; blk++) begin
      wide_mode = 1'($urandom_range(0, 1));
      dual_mode = ($urandom_range(0, 3) != 0);
      for (int i = 0; i < 100; i++) begin
        pa(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) != 0),
           9'($urandom_range(0, blk[0] ? 511 : 7)), 18'($urandom()));
        pb(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) != 0),
           9'($urandom_range(0, blk[0] ? 511 : 7)), 18'($urandom()));
        cyc();
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule